// File: doc/BRIEF.md
# Three-Port GPIO Interrupt Unit

This block serves three 8-line general-purpose I/O ports, called A, B and F. Each port has an output-value register and a direction register that drive the pads. It also has a per-line interrupt setup: an enable mask, a trigger-kind mask that selects level or edge, and a polarity mask that selects high/rising or low/falling. Every pad input passes through a two-stage synchroniser before it is used.

Edge events are held in a per-line latch until software acknowledges them by writing ones. Level conditions are never held: they are reported only while the pin is at its active level. Ports A and B share one interrupt line. Port F drives one interrupt line per pin, for a vectored controller that sits above this block.

Software reaches the registers through a simple single-cycle write strobe and a combinational read path, both selected by a port code and a register code.

Top module: `gpio_irq_hub`

## Requirements
- R1: After reset, every register reads 0, pad_oe and pad_out are 0, and irq_ab and irq_f are 0.
- R2: pad_oe mirrors the direction register (1 = output) and pad_out mirrors the output-value register, bit for bit.
- R3: Reading the data register returns the written value on output lines and the synchronised pin on input lines.
- R4: A line set to level mode (kind 0) with high polarity (1) reports status while its synchronised pin is 1. It reports nothing once the pin returns to 0.
- R5: A line set to level mode with low polarity (0) reports status while its synchronised pin is 0.
- R6: A line set to edge mode (kind 1) with rising polarity (1) latches a 0-to-1 transition. It keeps reporting it after the pin returns to 0.
- R7: A line set to edge mode with falling polarity (0) latches a 1-to-0 transition and ignores a 0-to-1 transition.
- R8: Writing the acknowledge register clears each latched edge whose bit is 1 and leaves lines with a 0 bit untouched. A level-mode line keeps reporting through an acknowledge.
- R9: A line whose enable bit is 0 reports no status. Clearing the enable bit discards a latched edge, so re-enabling the line does not bring the edge back.
- R10: irq_ab is the OR of all status bits of ports A and B.
- R11: irq_f[i] equals status bit i of port F.
- R12: A pin change reaches the status two clock edges after it is applied, and not after one.
- R13: Port codes are A=0, B=1, F=2. Port p uses pad bits 8p+7..8p. Register codes are 0 data, 1 direction, 2 enable, 3 trigger kind, 4 polarity, 5 status (read only), 6 acknowledge (write only, reads 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_port | input | 2 | Port code for a write |
| wr_sel | input | 3 | Register code for a write |
| wr_data | input | 8 | Write value |
| rd_port | input | 2 | Port code for a read |
| rd_sel | input | 3 | Register code for a read |
| rd_data | output | 8 | Read value (combinational) |
| pad_in | input | 24 | Raw pad inputs, 8 per port |
| pad_out | output | 24 | Pad output values |
| pad_oe | output | 24 | Pad output enables |
| irq_ab | output | 1 | Shared interrupt for ports A and B |
| irq_f | output | 8 | Per-line interrupts of port F |

## Verification
On every cycle, the assertions check these properties:
- A latched edge never survives a cleared enable bit.
- A latch only ever rises on an edge-mode line.
- An acknowledged bit that saw no new edge reads clear on the next cycle.
- A high-level status always matches the pin value from two edges earlier.

Other behaviours can only be shown by the directed scenarios:
- The two-edge latency, counted at the ports.
- Readback on mixed-direction lines.
- Falling-edge selectivity.
- Discarding a latched edge when its line is disabled and then re-enabled.
- The separate aggregation styles of the shared output and the per-line outputs.

// File: rtl/gpio_hub_pkg.sv
// Package: shared widths and register codes for the GPIO interrupt hub.
// Assumes all ports have the same line count.
package gpio_hub_pkg;
    localparam int LINES  = 8;
    localparam int NPORT  = 3;
    localparam int PORT_W = 2;
    localparam int SEL_W  = 3;

    localparam logic [SEL_W-1:0] SEL_DATA = 3'd0;
    localparam logic [SEL_W-1:0] SEL_DIR  = 3'd1;
    localparam logic [SEL_W-1:0] SEL_EN   = 3'd2;
    localparam logic [SEL_W-1:0] SEL_KIND = 3'd3;
    localparam logic [SEL_W-1:0] SEL_POL  = 3'd4;
    localparam logic [SEL_W-1:0] SEL_STAT = 3'd5;
    localparam logic [SEL_W-1:0] SEL_ACK  = 3'd6;
endpackage

// File: rtl/gpio_sync2.sv
// Module: two-flop synchroniser for a bus of independent pad inputs.
// Assumes each bit is treated on its own; no bus coherence is implied.
module gpio_sync2 #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] d_sync
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    // Shift the raw pins through two registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= d_in;
            stage2_q <= stage1_q;
        end
    end

    assign d_sync = stage2_q;
endmodule

// File: rtl/gpio_port_unit.sv
// Module: one GPIO port with output/direction registers and per-line
// interrupt detection (level or edge, either polarity).
// Assumes wr_hit is already decoded for this port. Status is unregistered
// and is built from the synchronised pins and the edge latches.
module gpio_port_unit
    import gpio_hub_pkg::*;
#(
    parameter int W = LINES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [W-1:0]     pad_in,
    input  logic             wr_hit,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [W-1:0]     wr_data,
    input  logic [SEL_W-1:0] rd_sel,
    output logic [W-1:0]     rd_data,
    output logic [W-1:0]     pad_out,
    output logic [W-1:0]     pad_oe,
    output logic [W-1:0]     stat
);
    logic [W-1:0] pin_s;
    logic [W-1:0] prev_q;
    logic [W-1:0] out_q, dir_q, en_q, kind_q, pol_q, latch_q;
    logic [W-1:0] en_d, latch_d, ack_mask, edge_hit, level_act;

    gpio_sync2 #(.W(W)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .d_in   (pad_in),
        .d_sync (pin_s)
    );

    // Edge of the selected polarity, against the previous synchronised value.
    assign edge_hit  = (pol_q & pin_s & ~prev_q) | (~pol_q & ~pin_s & prev_q);
    // Active level of the selected polarity.
    assign level_act = (pol_q & pin_s) | (~pol_q & ~pin_s);
    // Write-one acknowledge mask; zero when no acknowledge write is present.
    assign ack_mask  = (wr_hit && wr_sel == SEL_ACK) ? wr_data : '0;
    // Next enable value, so a clear and a discard happen on the same edge.
    assign en_d      = (wr_hit && wr_sel == SEL_EN) ? wr_data : en_q;
    // Latch set by an edge, cleared by acknowledge or by a disabled line.
    assign latch_d   = en_d & ((latch_q & ~ack_mask) | (kind_q & edge_hit));

    // Configuration registers written by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q  <= '0;
            dir_q  <= '0;
            kind_q <= '0;
            pol_q  <= '0;
        end else if (wr_hit) begin
            case (wr_sel)
                SEL_DATA: out_q  <= wr_data;
                SEL_DIR:  dir_q  <= wr_data;
                SEL_KIND: kind_q <= wr_data;
                SEL_POL:  pol_q  <= wr_data;
                default:  ;
            endcase
        end
    end

    // Enable mask, edge latches and the previous pin sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q    <= '0;
            latch_q <= '0;
            prev_q  <= '0;
        end else begin
            en_q    <= en_d;
            latch_q <= latch_d;
            prev_q  <= pin_s;
        end
    end

    // Pending status: latched edges, or live level conditions.
    assign stat = en_q & ((kind_q & latch_q) | (~kind_q & level_act));

    // Read mux: output lines read their driven value back.
    always_comb begin
        case (rd_sel)
            SEL_DATA: rd_data = (dir_q & out_q) | (~dir_q & pin_s);
            SEL_DIR:  rd_data = dir_q;
            SEL_EN:   rd_data = en_q;
            SEL_KIND: rd_data = kind_q;
            SEL_POL:  rd_data = pol_q;
            SEL_STAT: rd_data = stat;
            default:  rd_data = '0;
        endcase
    end

    assign pad_out = out_q;
    assign pad_oe  = dir_q;

    AST_NO_LATCH_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_q & ~en_q) == '0); // R9

    AST_LATCH_FROM_EDGE_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_q & ~$past(latch_q) & ~$past(kind_q)) == '0); // R6

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_mask != '0) |=> ((latch_q & $past(ack_mask & ~(kind_q & edge_hit))) == '0)); // R8

    AST_LEVEL_FOLLOWS_PIN: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat & en_q & ~kind_q & pol_q) & ~$past(pad_in, 2)) == '0); // R4
endmodule

// File: rtl/gpio_irq_hub.sv
// Module: top of the GPIO interrupt hub. It holds three port units, the
// shared read mux, and two aggregation styles: A and B share one output,
// and F has one output per line.
// Assumes a single write per cycle and the port order A, B, F.
module gpio_irq_hub
    import gpio_hub_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [PORT_W-1:0]      wr_port,
    input  logic [SEL_W-1:0]       wr_sel,
    input  logic [LINES-1:0]       wr_data,
    input  logic [PORT_W-1:0]      rd_port,
    input  logic [SEL_W-1:0]       rd_sel,
    output logic [LINES-1:0]       rd_data,
    input  logic [NPORT*LINES-1:0] pad_in,
    output logic [NPORT*LINES-1:0] pad_out,
    output logic [NPORT*LINES-1:0] pad_oe,
    output logic                   irq_ab,
    output logic [LINES-1:0]       irq_f
);
    localparam int SHARED = 2;

    logic [NPORT*LINES-1:0] stat_all;
    logic [LINES-1:0]       rd_arr [NPORT];

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        gpio_port_unit #(.W(LINES)) u_port (
            .clk     (clk),
            .rst_n   (rst_n),
            .pad_in  (pad_in[p*LINES +: LINES]),
            .wr_hit  (wr_en && (wr_port == PORT_W'(p))),
            .wr_sel  (wr_sel),
            .wr_data (wr_data),
            .rd_sel  (rd_sel),
            .rd_data (rd_arr[p]),
            .pad_out (pad_out[p*LINES +: LINES]),
            .pad_oe  (pad_oe[p*LINES +: LINES]),
            .stat    (stat_all[p*LINES +: LINES])
        );
    end

    // Pick the addressed port's read value; unused codes read 0.
    always_comb begin
        rd_data = '0;
        for (int p = 0; p < NPORT; p++)
            if (rd_port == PORT_W'(p)) rd_data = rd_arr[p];
    end

    assign irq_ab = |stat_all[SHARED*LINES-1:0];
    assign irq_f  = stat_all[SHARED*LINES +: LINES];
endmodule

// File: tb/gpio_irq_hub_test.sv
module gpio_irq_hub_test;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        wr_en = 0;
    logic [1:0]  wr_port = 0, rd_port = 0;
    logic [2:0]  wr_sel = 0, rd_sel = 0;
    logic [7:0]  wr_data = 0;
    logic [7:0]  rd_data;
    logic [23:0] pad_in = 0;
    logic [23:0] pad_out, pad_oe;
    logic        irq_ab;
    logic [7:0]  irq_f;
    int checks = 0, errors = 0;

    always #2 clk = ~clk;

    gpio_irq_hub uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_port(wr_port),
        .wr_sel(wr_sel), .wr_data(wr_data), .rd_port(rd_port),
        .rd_sel(rd_sel), .rd_data(rd_data), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .irq_ab(irq_ab), .irq_f(irq_f)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] p, input logic [2:0] s, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1; wr_port = p; wr_sel = s; wr_data = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic rd(input logic [1:0] p, input logic [2:0] s, output logic [7:0] d);
        rd_port = p; rd_sel = s;
        #1 d = rd_data;
    endtask

    task automatic wait_clk(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [7:0] v;
        for (int s = 0; s < 7; s++) begin
            rd(2'd0, 3'(s), v);
            check("R1 reg after reset", v, 0);
        end
        check("R1 pad_oe", pad_oe, 0);
        check("R1 pad_out", pad_out, 0);
        check("R1 irq_ab", irq_ab, 0);
        check("R1 irq_f", irq_f, 0);
    endtask

    task automatic t_dir_data;
        logic [7:0] v;
        wr(2'd0, 3'd1, 8'hF0);
        wr(2'd0, 3'd0, 8'hA5);
        check("R2 pad_oe", pad_oe[7:0], 8'hF0);
        check("R2 pad_out", pad_out[7:0], 8'hA5);
        @(negedge clk) pad_in[7:0] = 8'h0C;
        wait_clk(3);
        rd(2'd0, 3'd0, v);
        check("R3 mixed readback", v, 8'hAC);
        rd(2'd0, 3'd6, v);
        check("R13 ack reads zero", v, 0);
    endtask

    task automatic t_level_high;
        logic [7:0] v;
        wr(2'd1, 3'd3, 8'h00);
        wr(2'd1, 3'd4, 8'h01);
        wr(2'd1, 3'd2, 8'h01);
        rd(2'd1, 3'd5, v);
        check("R4 idle status", v & 8'h01, 0);
        @(negedge clk) pad_in[8] = 1;
        @(posedge clk) #1;
        rd(2'd1, 3'd5, v);
        check("R12 one edge too early", v & 8'h01, 0);
        @(posedge clk) #1;
        rd(2'd1, 3'd5, v);
        check("R12 after two edges", v & 8'h01, 8'h01);
        check("R10 irq_ab from B", irq_ab, 1);
        @(negedge clk) pad_in[8] = 0;
        wait_clk(3);
        rd(2'd1, 3'd5, v);
        check("R4 level not held", v & 8'h01, 0);
        check("R10 irq_ab drops", irq_ab, 0);
    endtask

    task automatic t_level_low;
        logic [7:0] v;
        @(negedge clk) pad_in[9] = 1;
        wait_clk(3);
        wr(2'd1, 3'd2, 8'h03);
        rd(2'd1, 3'd5, v);
        check("R5 inactive high pin", v & 8'h02, 0);
        @(negedge clk) pad_in[9] = 0;
        wait_clk(3);
        rd(2'd1, 3'd5, v);
        check("R5 low level", v & 8'h02, 8'h02);
        wr(2'd1, 3'd6, 8'hFF);
        rd(2'd1, 3'd5, v);
        check("R8 level ignores ack", v & 8'h02, 8'h02);
        @(negedge clk) pad_in[9] = 1;
        wait_clk(3);
        rd(2'd1, 3'd5, v);
        check("R5 cleared by pin", v & 8'h02, 0);
    endtask

    task automatic t_rise;
        logic [7:0] v;
        wr(2'd2, 3'd3, 8'h08);
        wr(2'd2, 3'd4, 8'h08);
        wr(2'd2, 3'd2, 8'h08);
        check("R11 irq_f idle", irq_f, 0);
        @(negedge clk) pad_in[19] = 1;
        wait_clk(4);
        check("R11 irq_f line3", irq_f, 8'h08);
        @(negedge clk) pad_in[19] = 0;
        wait_clk(4);
        rd(2'd2, 3'd5, v);
        check("R6 held after pin low", v, 8'h08);
        wr(2'd2, 3'd6, 8'hF7);
        check("R8 zero bit no effect", irq_f, 8'h08);
        wr(2'd2, 3'd6, 8'h08);
        check("R8 ack clears", irq_f, 0);
    endtask

    task automatic t_fall;
        wr(2'd2, 3'd3, 8'h28);
        wr(2'd2, 3'd2, 8'h28);
        @(negedge clk) pad_in[21] = 1;
        wait_clk(4);
        check("R7 rise ignored", irq_f, 0);
        @(negedge clk) pad_in[21] = 0;
        wait_clk(4);
        check("R7 fall latched", irq_f, 8'h20);
    endtask

    task automatic t_disable;
        wr(2'd2, 3'd2, 8'h08);
        check("R9 disabled quiet", irq_f, 0);
        wr(2'd2, 3'd2, 8'h28);
        check("R9 latch discarded", irq_f, 0);
        wr(2'd0, 3'd1, 8'h00);
        wr(2'd0, 3'd4, 8'hFF);
        @(negedge clk) pad_in[7:0] = 8'hFF;
        wait_clk(4);
        check("R9 port A not enabled", irq_ab, 0);
        wr(2'd0, 3'd2, 8'h80);
        check("R10 irq_ab from A", irq_ab, 1);
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        wait_clk(3);
        rst_n = 1;
        wait_clk(1);
        t_reset;
        t_dir_data;
        t_level_high;
        t_level_low;
        t_rise;
        t_fall;
        t_disable;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule